// File: doc/BRIEF.md
# Translation Buffer Fill and Invalidate Controller

This block holds a small fully associative translation buffer and maintains it only through writes to a handful of control registers. Software first writes a page table entry into a staging register. A later write to the tag register then commits the tag, the staged entry and the current address space id together into one buffer slot. Slots are chosen in round-robin order. Three separate control writes remove entries: one clears the whole buffer, one clears every entry that is not marked global, and one clears the entry that matches a given address within the current address space.

Staging is tracked by a three-state controller. `ST_EMPTY` means nothing has been staged since reset, and a tag write is ignored there. A staging write moves it to `ST_ARMED` (transition *arm*). From `ST_ARMED`, a tag write with a clean granularity-hint field commits an entry and stays in `ST_ARMED` (transition *commit*). A tag write with a nonzero hint moves it to `ST_FAULT` (transition *reject*), and `ST_FAULT` raises the error output for one cycle. `ST_FAULT` behaves as `ST_ARMED` for the next write and otherwise returns to `ST_ARMED` (transition *recover*). The staged value persists after a commit, so a second tag write commits it again into the next slot.

An index-driven probe port shows any slot's valid bit, tag and packed view. A read port returns the staged entry packed into a 64-bit word along with the other register values.

Top module: `tlb_fill_unit`

## Requirements
- R1: After reset every slot is invalid, the round-robin pointer is at slot 0, the controller is in `ST_EMPTY`, `fill_err` is 0 and every read select returns 0.
- R2: A write with `wr_sel`=0 (staging) stores the 64-bit value and changes no slot. Reading select 0 returns the packed view: frame number `[58:32]` = staged `[58:32]`, read enables `[11:8]`, write enables `[15:12]`, fault-on-read bit 1, fault-on-write bit 2 and global bit 4, each taken from the same bit positions of the staged value, ORed with the current address space id placed at `[63:57]`.
- R3: A write with `wr_sel`=1 (tag) in `ST_ARMED` with staged bits `[6:5]`=0 fills the slot at the pointer. The slot is made valid with tag = data `[42:13]`, the staged fields and the current id. The pointer then advances, wrapping from the last slot to 0.
- R4: A tag write in `ST_EMPTY` changes no slot, does not move the pointer and does not raise `fill_err`.
- R5: A tag write while staged bits `[6:5]` are nonzero fills no slot and leaves the pointer unchanged. It raises `fill_err` for exactly the cycle after the write.
- R6: A write with `wr_sel`=3 invalidates every slot. Read select 3 always returns 0.
- R7: A write with `wr_sel`=4 invalidates every slot whose global bit is 0 and keeps the global ones. Read select 4 always returns 0.
- R8: A write with `wr_sel`=5 invalidates each valid slot whose tag equals data `[42:13]` and that is either global or tagged with the current id. Read select 5 returns the last value written there.
- R9: A write with `wr_sel`=2 sets the current id to data `[63:57]`. Read select 2 returns it at `[63:57]`. Slots already filled keep the id they were filled with.
- R10: The probe port shows, for slot `probe_idx`, its valid bit, its tag and its packed view in the R2 layout with the slot's own id.
- R11: Read select 1 returns the last raw value written to the tag register. Select codes 6 and 7 write nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 64 | Write value |
| rd_sel | input | 3 | Register select for readback |
| rd_data | output | 64 | Readback value (combinational) |
| probe_idx | input | 3 | Slot to show on the probe port |
| probe_valid | output | 1 | Valid bit of the probed slot |
| probe_tag | output | 30 | Tag of the probed slot |
| probe_word | output | 64 | Packed entry view of the probed slot |
| fill_err | output | 1 | One-cycle error on a rejected commit |

## Verification
The bench uses random write sequences over a deliberately small tag set and id set, so single invalidates hit real matches, near misses on the id only, and global entries. Long runs of commits show that the slot order wraps and that an older slot is overwritten, not appended. Directed cases cover a tag write before any staging, a rejected hint, an id change between fills, and a process invalidate over a mix of global and private slots. These separate invalidate scope errors from fill errors. After every write, each slot and every readback register is compared against a model.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;

    localparam int WORD_W   = 64;
    localparam int PFN_W    = 27;
    localparam int ASID_W   = 7;
    localparam int PERM_W   = 4;
    localparam int GH_W     = 2;

    localparam int PFN_LSB  = 32;
    localparam int RE_LSB   = 8;
    localparam int WE_LSB   = 12;
    localparam int FOR_BIT  = 1;
    localparam int FOW_BIT  = 2;
    localparam int GLB_BIT  = 4;
    localparam int GH_LSB   = 5;
    localparam int ASID_LSB = 57;

    typedef enum logic [2:0] {
        REG_STAGE      = 3'd0,
        REG_TAG        = 3'd1,
        REG_ASID       = 3'd2,
        REG_FLUSH_ALL  = 3'd3,
        REG_FLUSH_PROC = 3'd4,
        REG_FLUSH_ONE  = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ARMED = 2'd1,
        ST_FAULT = 2'd2
    } fill_st_e;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] rd_ok;
        logic [PERM_W-1:0] wr_ok;
        logic              flt_rd;
        logic              flt_wr;
        logic              glb;
    } pte_t;

    function automatic pte_t unpack_pte(input logic [WORD_W-1:0] w);
        pte_t p;
        p.pfn    = w[PFN_LSB +: PFN_W];
        p.rd_ok  = w[RE_LSB +: PERM_W];
        p.wr_ok  = w[WE_LSB +: PERM_W];
        p.flt_rd = w[FOR_BIT];
        p.flt_wr = w[FOW_BIT];
        p.glb    = w[GLB_BIT];
        return p;
    endfunction

    function automatic logic [WORD_W-1:0] pack_view(input pte_t p,
                                                    input logic [ASID_W-1:0] a);
        logic [WORD_W-1:0] w;
        w = '0;
        w = w | (WORD_W'(p.pfn)   << PFN_LSB);
        w = w | (WORD_W'(p.rd_ok) << RE_LSB);
        w = w | (WORD_W'(p.wr_ok) << WE_LSB);
        w = w | (WORD_W'(p.flt_rd) << FOR_BIT);
        w = w | (WORD_W'(p.flt_wr) << FOW_BIT);
        w = w | (WORD_W'(p.glb)    << GLB_BIT);
        w = w | (WORD_W'(a)        << ASID_LSB);
        return w;
    endfunction

endpackage

// File: rtl/tlbf_ctrl.sv
module tlbf_ctrl
    import tlbf_pkg::*;
#(
    parameter int TAG_W   = 30,
    parameter int TAG_LSB = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [2:0]        rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output pte_t              staged_pte,
    output logic [ASID_W-1:0] cur_asid,
    output logic              commit,
    output logic [TAG_W-1:0]  addr_tag,
    output logic              flush_all,
    output logic              flush_proc,
    output logic              flush_one,
    output logic              fill_err
);

    fill_st_e          state_q, state_d;
    logic [WORD_W-1:0] staged_q;
    logic [WORD_W-1:0] tag_raw_q;
    logic [WORD_W-1:0] one_raw_q;
    logic [ASID_W-1:0] asid_q;

    logic stage_wr, tag_wr, asid_wr, one_wr;
    logic hint_bad;

    always_comb begin
        stage_wr   = wr_en && (wr_sel == REG_STAGE);
        tag_wr     = wr_en && (wr_sel == REG_TAG);
        asid_wr    = wr_en && (wr_sel == REG_ASID);
        one_wr     = wr_en && (wr_sel == REG_FLUSH_ONE);
        hint_bad   = |staged_q[GH_LSB +: GH_W];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (stage_wr) state_d = ST_ARMED;           // arm
            end
            ST_ARMED, ST_FAULT: begin
                if (tag_wr && hint_bad) state_d = ST_FAULT; // reject
                else                    state_d = ST_ARMED; // commit / recover
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q  <= '0;
            tag_raw_q <= '0;
            one_raw_q <= '0;
            asid_q    <= '0;
        end else begin
            if (stage_wr) staged_q  <= wr_data;
            if (tag_wr)   tag_raw_q <= wr_data;
            if (one_wr)   one_raw_q <= wr_data;
            if (asid_wr)  asid_q    <= wr_data[ASID_LSB +: ASID_W];
        end
    end

    // outputs
    always_comb begin
        staged_pte = unpack_pte(staged_q);
        cur_asid   = asid_q;
        addr_tag   = wr_data[TAG_LSB +: TAG_W];
        commit     = tag_wr && (state_q != ST_EMPTY) && !hint_bad;
        flush_all  = wr_en && (wr_sel == REG_FLUSH_ALL);
        flush_proc = wr_en && (wr_sel == REG_FLUSH_PROC);
        flush_one  = one_wr;
        fill_err   = (state_q == ST_FAULT);
        unique case (rd_sel)
            REG_STAGE:     rd_data = pack_view(staged_pte, asid_q);
            REG_TAG:       rd_data = tag_raw_q;
            REG_ASID:      rd_data = WORD_W'(asid_q) << ASID_LSB;
            REG_FLUSH_ONE: rd_data = one_raw_q;
            default:       rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tlbf_array.sv
module tlbf_array
    import tlbf_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 30,
    parameter int PTR_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [TAG_W-1:0]  addr_tag,
    input  pte_t              staged_pte,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              flush_all,
    input  logic              flush_proc,
    input  logic              flush_one,
    input  logic [PTR_W-1:0]  probe_idx,
    output logic              probe_valid,
    output logic [TAG_W-1:0]  probe_tag,
    output logic [WORD_W-1:0] probe_word,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] glb_vec,
    output logic [PTR_W-1:0]  rr_ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [ASID_W-1:0]  asid_q [ENTRIES];
    pte_t               pte_q  [ENTRIES];
    logic [PTR_W-1:0]   ptr_q;

    // round-robin fill pointer
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (commit) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic hit_one;
        logic fill_me;
        always_comb begin
            hit_one = valid_q[g] && (tag_q[g] == addr_tag) &&
                      (pte_q[g].glb || (asid_q[g] == cur_asid));
            fill_me = commit && (ptr_q == PTR_W'(g));
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
                asid_q[g]  <= '0;
                pte_q[g]   <= '0;
            end else begin
                if (flush_all)                      valid_q[g] <= 1'b0;
                else if (flush_proc && !pte_q[g].glb) valid_q[g] <= 1'b0;
                else if (flush_one && hit_one)      valid_q[g] <= 1'b0;
                if (fill_me) begin
                    valid_q[g] <= 1'b1;
                    tag_q[g]   <= addr_tag;
                    asid_q[g]  <= cur_asid;
                    pte_q[g]   <= staged_pte;
                end
            end
        end

        assign glb_vec[g] = pte_q[g].glb;
    end

    always_comb begin
        valid_vec = valid_q;
        rr_ptr    = ptr_q;
        if (int'(probe_idx) < ENTRIES) begin
            probe_valid = valid_q[probe_idx];
            probe_tag   = tag_q[probe_idx];
            probe_word  = pack_view(pte_q[probe_idx], asid_q[probe_idx]);
        end else begin
            probe_valid = 1'b0;
            probe_tag   = '0;
            probe_word  = '0;
        end
    end

endmodule

// File: rtl/tlb_fill_unit.sv
module tlb_fill_unit
    import tlbf_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 30,
    parameter int TAG_LSB = 13,
    parameter int PTR_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [63:0]        wr_data,
    input  logic [2:0]         rd_sel,
    output logic [63:0]        rd_data,
    input  logic [PTR_W-1:0]   probe_idx,
    output logic               probe_valid,
    output logic [TAG_W-1:0]   probe_tag,
    output logic [63:0]        probe_word,
    output logic               fill_err
);

    pte_t               staged_pte;
    logic [ASID_W-1:0]  cur_asid;
    logic               commit;
    logic [TAG_W-1:0]   addr_tag;
    logic               flush_all, flush_proc, flush_one;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] glb_vec;
    logic [PTR_W-1:0]   rr_ptr;

    tlbf_ctrl #(
        .TAG_W   (TAG_W),
        .TAG_LSB (TAG_LSB)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .staged_pte (staged_pte),
        .cur_asid   (cur_asid),
        .commit     (commit),
        .addr_tag   (addr_tag),
        .flush_all  (flush_all),
        .flush_proc (flush_proc),
        .flush_one  (flush_one),
        .fill_err   (fill_err)
    );

    tlbf_array #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .PTR_W   (PTR_W)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .addr_tag    (addr_tag),
        .staged_pte  (staged_pte),
        .cur_asid    (cur_asid),
        .flush_all   (flush_all),
        .flush_proc  (flush_proc),
        .flush_one   (flush_one),
        .probe_idx   (probe_idx),
        .probe_valid (probe_valid),
        .probe_tag   (probe_tag),
        .probe_word  (probe_word),
        .valid_vec   (valid_vec),
        .glb_vec     (glb_vec),
        .rr_ptr      (rr_ptr)
    );

endmodule

// File: rtl/tlbf_chk.sv
module tlbf_chk #(
    parameter int ENTRIES = 8,
    parameter int PTR_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [2:0]         wr_sel,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] glb_vec,
    input logic [PTR_W-1:0]   rr_ptr,
    input logic               fill_err
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    // R6
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd3) |=> (valid_vec == '0));

    // R7
    flush_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd4) |=> ((valid_vec & ~glb_vec) == '0));

    // R2
    stage_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd0) |=> ($stable(valid_vec) && $stable(rr_ptr)));

    // R5
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_err |-> $past(wr_en && wr_sel == 3'd1));

    // R5
    err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_err |-> ($stable(valid_vec) && $stable(rr_ptr)));

    // R3
    rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_ptr != $past(rr_ptr)) |->
            (rr_ptr == (($past(rr_ptr) == LAST) ? '0 : $past(rr_ptr) + 1'b1)));

endmodule

bind tlb_fill_unit tlbf_chk #(
    .ENTRIES (ENTRIES),
    .PTR_W   (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .valid_vec (valid_vec),
    .glb_vec   (glb_vec),
    .rr_ptr    (rr_ptr),
    .fill_err  (fill_err)
);

// File: tb/tlb_fill_unit_bench.sv
`timescale 1ns/1ps
module tlb_fill_unit_bench;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic [2:0]  probe_idx = '0;
    logic        probe_valid;
    logic [29:0] probe_tag;
    logic [63:0] probe_word;
    logic        fill_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tlb_fill_unit u_tlb_fill_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .probe_idx(probe_idx), .probe_valid(probe_valid),
        .probe_tag(probe_tag), .probe_word(probe_word), .fill_err(fill_err)
    );

    // reference model
    logic        m_valid [N];
    logic [29:0] m_tag   [N];
    logic [6:0]  m_easid [N];
    logic [63:0] m_raw   [N];
    int          m_ptr;
    bit          m_armed;
    logic [63:0] m_staged, m_tag_raw, m_one_raw;
    logic [6:0]  m_asid;
    logic        m_err;

    function automatic logic [63:0] view(input logic [63:0] raw, input logic [6:0] a);
        logic [63:0] w;
        w = 64'd0;
        w[58:32] = raw[58:32];
        w[11:8]  = raw[11:8];
        w[15:12] = raw[15:12];
        w[1] = raw[1];
        w[2] = raw[2];
        w[4] = raw[4];
        w[63:57] = w[63:57] | a;
        return w;
    endfunction

    function automatic logic [63:0] exp_rd(input int s);
        case (s)
            0: return view(m_staged, m_asid);
            1: return m_tag_raw;
            2: return {m_asid, 57'd0};
            5: return m_one_raw;
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_tag[i] = '0; m_easid[i] = '0; m_raw[i] = '0;
        end
        m_ptr = 0; m_armed = 0; m_staged = '0; m_tag_raw = '0;
        m_one_raw = '0; m_asid = '0; m_err = 0;
    endtask

    task automatic check_all(input string req);
        check({req, " err"}, 64'(fill_err), 64'(m_err));
        for (int s = 0; s < 8; s++) begin
            rd_sel = 3'(s);
            #0.3;
            check({req, " rd"}, rd_data, exp_rd(s));
        end
        for (int i = 0; i < N; i++) begin
            probe_idx = 3'(i);
            #0.3;
            check({req, " R10 valid"}, 64'(probe_valid), 64'(m_valid[i]));
            if (m_valid[i]) begin
                check({req, " R10 tag"}, 64'(probe_tag), 64'(m_tag[i]));
                check({req, " R10 word"}, probe_word, view(m_raw[i], m_easid[i]));
            end
        end
    endtask

    task automatic wr(input int sel, input logic [63:0] d, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_err = 0;
        case (sel)
            0: begin m_staged = d; m_armed = 1; end
            1: begin
                m_tag_raw = d;
                if (m_armed) begin
                    if (m_staged[6:5] != 2'b00) m_err = 1;
                    else begin
                        m_valid[m_ptr] = 1;
                        m_tag[m_ptr]   = d[42:13];
                        m_easid[m_ptr] = m_asid;
                        m_raw[m_ptr]   = m_staged;
                        m_ptr = (m_ptr + 1) % N;
                    end
                end
            end
            2: m_asid = d[63:57];
            3: for (int i = 0; i < N; i++) m_valid[i] = 0;
            4: for (int i = 0; i < N; i++) if (!m_raw[i][4]) m_valid[i] = 0;
            5: begin
                m_one_raw = d;
                for (int i = 0; i < N; i++)
                    if (m_valid[i] && m_tag[i] == d[42:13] &&
                        (m_raw[i][4] || m_easid[i] == m_asid)) m_valid[i] = 0;
            end
            default: ;
        endcase
        check_all(req);
    endtask

    function automatic logic [63:0] mk_tag(input int t);
        logic [63:0] d;
        d = {$urandom, $urandom};
        d[42:13] = 30'(t * 30'h0123457 + 5);
        return d;
    endfunction

    function automatic logic [63:0] mk_stage(input bit glb, input bit bad);
        logic [63:0] d;
        d = {$urandom, $urandom};
        d[4] = glb;
        d[6:5] = bad ? 2'b10 : 2'b00;
        return d;
    endfunction

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        check_all("R1 reset");

        // R4: tag write with nothing staged
        wr(1, mk_tag(1), "R4 tag before stage");
        wr(2, {7'd3, 57'd0}, "R9 asid set");
        // R2: staging only
        wr(0, mk_stage(0, 0), "R2 stage");
        // R3: fill past the last slot to wrap
        for (int k = 0; k < N + 2; k++) begin
            if (k == 4) wr(2, {7'd9, 57'd0}, "R9 asid change");
            wr(0, mk_stage(k[0], 0), "R2 stage");
            wr(1, mk_tag(k % 3), "R3 fill wrap");
        end
        // R3: staged value reused by a second tag write
        wr(1, mk_tag(2), "R3 reuse staged");
        // R5: rejected hint
        wr(0, mk_stage(1, 1), "R2 stage bad hint");
        wr(1, mk_tag(0), "R5 reject");
        wr(1, mk_tag(1), "R5 reject again");
        wr(0, mk_stage(0, 0), "R5 recover");
        check("R5 err clears", 64'(fill_err), 64'd0);
        // R8: single invalidate, id miss then hit
        wr(5, mk_tag(1), "R8 single current id");
        wr(2, {7'd3, 57'd0}, "R9 asid back");
        wr(5, mk_tag(0), "R8 single other id");
        // R7 then R6
        wr(4, 64'hFFFF, "R7 process flush");
        wr(3, 64'hFFFF_FFFF, "R6 flush all");
        // R11: unused selects
        wr(6, 64'hDEAD, "R11 sel6");
        wr(7, 64'hBEEF, "R11 sel7");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom % 16);
            if (op < 5)       wr(0, mk_stage($urandom % 2, ($urandom % 8) == 0), "R2 rnd stage");
            else if (op < 10) wr(1, mk_tag(int'($urandom % 4)), "R3 rnd fill");
            else if (op < 12) wr(2, {7'($urandom % 4), 57'($urandom)}, "R9 rnd asid");
            else if (op < 14) wr(5, mk_tag(int'($urandom % 4)), "R8 rnd single");
            else if (op == 14) wr(4, {$urandom, $urandom}, "R7 rnd process");
            else if (($urandom % 4) == 0) wr(3, {$urandom, $urandom}, "R6 rnd all");
            else wr(1, mk_tag(int'($urandom % 4)), "R3 rnd fill");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule